// File: doc/BRIEF.md
# Two-Signal Edge Separation Timer

The block measures the time from an active edge on a start input (`aux_in`) to the next active edge on a stop input (`gate_in`). It does this by counting timebase ticks (`src_tick`) between the two events. Each input has its own polarity select, so either the rising or the falling transition can be the active one. Measurement only runs while `arm` is high.

A sample clock (`smp_clk`) divides time into periods. On each rising edge of the sample clock, the most recent separation completed in that period is written into a small first-word-fall-through FIFO, which a consumer drains with `pop`. A period that ends with no completed separation raises a sticky overrun flag. A write that finds the FIFO full is dropped and raises a sticky overflow flag. `clear` resets both flags.

Top module: `edge_sep_timer`

## Requirements
- R1: While `arm` is low, no measurement starts, any measurement in progress is abandoned, and sample-clock edges neither write the FIFO nor set `overrun`.
- R2: Each of `aux_in` and `gate_in` has its own polarity select (1 = rising edge active, 0 = falling edge active). A transition in the inactive direction has no effect.
- R3: An active `aux_in` edge while idle and armed starts a measurement from zero. The result is the number of cycles with `src_tick` high, counted from the cycle after the start edge through the stop-edge cycle inclusive.
- R4: An active `gate_in` edge during a measurement completes it. An active `gate_in` edge while idle is ignored.
- R5: An active `aux_in` edge during a measurement is ignored; the count continues and is not restarted.
- R6: The count saturates at its all-ones value (CNT_W bits) rather than wrapping.
- R7: On a rising edge of `smp_clk`, the latest separation completed since the previous sample edge is written to the FIFO once. A completion in the same cycle as the sample edge counts for that period and takes precedence.
- R8: A rising `smp_clk` edge with no completed separation in its period sets `overrun`. The flag stays set until `clear` is high. If a new overrun event occurs in the same cycle as `clear`, the flag stays set.
- R9: The FIFO shows its oldest entry on `fifo_data`, with `fifo_valid` high whenever it is non-empty. `pop` with `fifo_valid` high removes the head. A write becomes visible the cycle after the sample edge.
- R10: A write into a full FIFO (FIFO_DEPTH entries, with no pop in the same cycle) is dropped and sets `overflow`, which stays set until `clear`. Stored entries are kept.
- R11: After synchronous reset, the FIFO is empty, both flags are low and no measurement is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Enables measurement and sampling |
| clear | input | 1 | Clears the overrun and overflow flags |
| aux_in | input | 1 | Start-event input |
| aux_pol | input | 1 | Active edge of aux_in: 1 rising, 0 falling |
| gate_in | input | 1 | Stop-event input |
| gate_pol | input | 1 | Active edge of gate_in: 1 rising, 0 falling |
| src_tick | input | 1 | Timebase tick, counted when high |
| smp_clk | input | 1 | Sample clock; its rising edge closes a period |
| pop | input | 1 | Removes the FIFO head |
| fifo_data | output | CNT_W | Oldest stored separation |
| fifo_valid | output | 1 | FIFO is non-empty |
| overrun | output | 1 | Sticky: a period had no completed separation |
| overflow | output | 1 | Sticky: a result was dropped because the FIFO was full |

## Verification
The assertions check the following on every cycle:
- the run state collapses whenever `arm` falls;
- a running count never decreases until the stop edge, and stays pinned once it saturates;
- the FIFO occupancy never passes its depth, and a full FIFO with no pop stays full;
- `overrun` holds until cleared;
- a sample write consumes the held result.

Only the bench scenarios can show the following:
- the exact tick counts;
- that inactive-polarity transitions, idle stop edges and repeated start edges are ignored;
- that the newest result wins within a period;
- that `overrun` wins when it is set in the same cycle as `clear`;
- the drop policy on a full FIFO.

// File: rtl/est_pkg.sv
// Package: shared types for the edge separation timer.
// Assumes: all inputs are synchronous to clk.
package est_pkg;
    typedef enum logic {
        SEP_IDLE = 1'b0,
        SEP_RUN  = 1'b1
    } sep_state_e;

    // Channel indices into the edge detector bank.
    localparam int CH_AUX  = 0;
    localparam int CH_GATE = 1;
    localparam int CH_SMP  = 2;
    localparam int CH_NUM  = 3;
endpackage

// File: rtl/est_edge.sv
// Module: bank of polarity-selectable edge detectors.
// Each channel flags one cycle when its input has just changed to the level
// given by its polarity bit (1 = rising edge active, 0 = falling edge active).
// Assumes: inputs are synchronous to clk and held low through reset.
module est_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    input  logic [N-1:0] pol_i,
    output logic [N-1:0] edge_o
);
    for (genvar k = 0; k < N; k++) begin : g_ch
        logic prev_q;

        // Remember last cycle's level of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= sig_i[k];
        end

        assign edge_o[k] = (sig_i[k] != prev_q) && (sig_i[k] == pol_i[k]);
    end
endmodule

// File: rtl/est_span.sv
// Module: start/stop tick counter.
// A start pulse while idle clears the count and enters run. In run, ticks add
// to the count with saturation. A stop pulse presents the final value on
// span_o together with done_o for that cycle. Dropping arm forces idle.
// Assumes: start_i/stop_i are single-cycle edge pulses.
module est_span
    import est_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             tick_i,
    output logic             done_o,
    output logic [CNT_W-1:0] span_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    sep_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    // Saturating increment of the running count.
    always_comb begin
        if (cnt_q == CNT_MAX) cnt_nxt = cnt_q;
        else                  cnt_nxt = cnt_q + CNT_W'(tick_i);
    end

    assign done_o = arm_i && (state_q == SEP_RUN) && stop_i;
    assign span_o = cnt_nxt;

    // Run/idle sequencing and count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEP_IDLE;
            cnt_q   <= '0;
        end else if (!arm_i) begin
            state_q <= SEP_IDLE;
        end else if (state_q == SEP_IDLE) begin
            if (start_i) begin
                state_q <= SEP_RUN;
                cnt_q   <= '0;
            end
        end else begin
            cnt_q <= cnt_nxt;
            if (stop_i) state_q <= SEP_IDLE;
        end
    end

    // R1: disarming always returns to idle.
    a_r1_idle_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> (state_q == SEP_IDLE));
    // R3: run is only entered from an armed start pulse.
    a_r3_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == SEP_RUN) |-> $past(start_i && arm_i));
    // R4: an armed stop pulse in run ends the measurement.
    a_r4_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (state_q == SEP_IDLE));
    // R5: the count never drops while running (no restart on repeated start).
    a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEP_RUN && arm_i && !stop_i) |=> (cnt_q >= $past(cnt_q)));
    // R6: a saturated count stays saturated.
    a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEP_RUN && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/est_sampler.sv
// Module: per-period result selection and overrun flag.
// Holds the newest completed span. On a sample edge, it emits that span (or
// the span completing in the same cycle) as a write request. If no span
// completed in the period, it raises the sticky overrun flag instead.
// Assumes: done_i/smp_i are single-cycle pulses.
module est_sampler #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             clear_i,
    input  logic             smp_i,
    input  logic             done_i,
    input  logic [CNT_W-1:0] span_i,
    output logic             push_o,
    output logic [CNT_W-1:0] push_data_o,
    output logic             overrun_o
);
    logic             pend_q;
    logic [CNT_W-1:0] hold_q;
    logic             ovr_q;
    logic             ovr_set;

    assign push_o      = arm_i && smp_i && (done_i || pend_q);
    assign push_data_o = done_i ? span_i : hold_q;
    assign ovr_set     = arm_i && smp_i && !done_i && !pend_q;
    assign overrun_o   = ovr_q;

    // Track the newest completed span of the current period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            hold_q <= '0;
        end else if (!arm_i) begin
            pend_q <= 1'b0;
        end else if (smp_i) begin
            pend_q <= 1'b0;
        end else if (done_i) begin
            pend_q <= 1'b1;
            hold_q <= span_i;
        end
    end

    // Sticky overrun; a new event beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= ovr_set || (ovr_q && !clear_i);
    end

    // R8: overrun holds until cleared.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !clear_i) |=> ovr_q);
    // R7: a write consumes the held result.
    a_r7_consume: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !pend_q);
    // R1: nothing is written while disarmed.
    a_r1_no_push_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |-> !push_o);
endmodule

// File: rtl/est_fifo.sv
// Module: first-word-fall-through result FIFO with a sticky overflow flag.
// A write that finds no room (full, and no pop this cycle) is dropped.
// Assumes: DEPTH >= 2.
module est_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] data_o,
    output logic         valid_o,
    output logic         overflow_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] count_q;
    logic          ovf_q;
    logic          do_pop, do_push, room;

    assign do_pop     = pop_i && (count_q != '0);
    assign room       = (count_q != CW'(DEPTH)) || do_pop;
    assign do_push    = push_i && room;
    assign data_o     = mem[rd_q];
    assign valid_o    = (count_q != '0);
    assign overflow_o = ovf_q;

    // Store the accepted write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= push_data_i;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            count_q <= count_q + CW'(do_push) - CW'(do_pop);
        end
    end

    // Sticky overflow; a new drop beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= (push_i && !room) || (ovf_q && !clear_i);
    end

    // R10: occupancy never exceeds the depth.
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));
    // R10: a full FIFO with no pop stays full, whatever is written.
    a_r10_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CW'(DEPTH) && !pop_i) |=> (count_q == CW'(DEPTH)));
    // R9: a pop on a non-empty FIFO without a write lowers occupancy.
    a_r9_pop_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && pop_i && !push_i) |=> (count_q == $past(count_q) - 1'b1));
endmodule

// File: rtl/edge_sep_timer.sv
// Module: two-signal edge separation timer (top).
// Counts src_tick from an active aux_in edge to the next active gate_in edge.
// On each rising smp_clk edge, it writes the newest result into a FIFO, or
// flags overrun if the period had none.
// Assumes: all inputs synchronous to clk; inputs low during reset.
module edge_sep_timer
    import est_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int FIFO_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             clear,
    input  logic             aux_in,
    input  logic             aux_pol,
    input  logic             gate_in,
    input  logic             gate_pol,
    input  logic             src_tick,
    input  logic             smp_clk,
    input  logic             pop,
    output logic [CNT_W-1:0] fifo_data,
    output logic             fifo_valid,
    output logic             overrun,
    output logic             overflow
);
    logic [CH_NUM-1:0] sig_vec, pol_vec, edge_vec;
    logic              done;
    logic [CNT_W-1:0]  span;
    logic              push;
    logic [CNT_W-1:0]  push_data;

    // Pack the channels; the sample clock is always rising-edge active.
    always_comb begin
        sig_vec          = '0;
        pol_vec          = '0;
        sig_vec[CH_AUX]  = aux_in;
        pol_vec[CH_AUX]  = aux_pol;
        sig_vec[CH_GATE] = gate_in;
        pol_vec[CH_GATE] = gate_pol;
        sig_vec[CH_SMP]  = smp_clk;
        pol_vec[CH_SMP]  = 1'b1;
    end

    est_edge #(.N(CH_NUM)) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (sig_vec),
        .pol_i  (pol_vec),
        .edge_o (edge_vec)
    );

    est_span #(.CNT_W(CNT_W)) span_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (arm),
        .start_i (edge_vec[CH_AUX]),
        .stop_i  (edge_vec[CH_GATE]),
        .tick_i  (src_tick),
        .done_o  (done),
        .span_o  (span)
    );

    est_sampler #(.CNT_W(CNT_W)) smp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (arm),
        .clear_i     (clear),
        .smp_i       (edge_vec[CH_SMP]),
        .done_i      (done),
        .span_i      (span),
        .push_o      (push),
        .push_data_o (push_data),
        .overrun_o   (overrun)
    );

    est_fifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear),
        .push_i      (push),
        .push_data_i (push_data),
        .pop_i       (pop),
        .data_o      (fifo_data),
        .valid_o     (fifo_valid),
        .overflow_o  (overflow)
    );
endmodule

// File: tb/edge_sep_timer_tb_top.sv
module edge_sep_timer_tb_top;
    localparam int CW    = 8;
    localparam int DEPTH = 4;
    localparam int unsigned MAXV = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 0, clear = 0, aux = 0, aux_pol = 1, gate = 0, gate_pol = 1;
    logic tick = 0, smp = 0, pop = 0;
    logic [CW-1:0] fifo_data;
    logic fifo_valid, overrun, overflow;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    edge_sep_timer #(.CNT_W(CW), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .arm(arm), .clear(clear),
        .aux_in(aux), .aux_pol(aux_pol), .gate_in(gate), .gate_pol(gate_pol),
        .src_tick(tick), .smp_clk(smp), .pop(pop),
        .fifo_data(fifo_data), .fifo_valid(fifo_valid),
        .overrun(overrun), .overflow(overflow)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge.
    bit m_pa, m_pg, m_ps, m_run, m_pend, m_ovr, m_ovf;
    int unsigned m_cnt, m_hold;
    int unsigned q[$];

    always @(posedge clk) begin
        bit ae, ge, se, done, push, ovr_set, ovf_set;
        int unsigned nx, pv, pdata;
        if (!rst_n) begin
            m_pa = 0; m_pg = 0; m_ps = 0; m_run = 0; m_pend = 0;
            m_ovr = 0; m_ovf = 0; m_cnt = 0; m_hold = 0;
            q.delete();
        end else begin
            ae = (aux != m_pa) && (aux == aux_pol);
            ge = (gate != m_pg) && (gate == gate_pol);
            se = smp && !m_ps;
            done = 0; pv = 0; push = 0; pdata = 0; ovr_set = 0; ovf_set = 0;
            if (!arm) m_run = 0;
            else if (m_run) begin
                nx = (m_cnt + 32'(tick) > MAXV) ? MAXV : m_cnt + 32'(tick);
                m_cnt = nx;
                if (ge) begin done = 1; pv = nx; m_run = 0; end
            end else if (ae) begin
                m_run = 1; m_cnt = 0;
            end
            if (arm && se) begin
                if (done) begin push = 1; pdata = pv; end
                else if (m_pend) begin push = 1; pdata = m_hold; end
                else ovr_set = 1;
                m_pend = 0;
            end else if (done) begin
                m_pend = 1; m_hold = pv;
            end
            if (!arm) m_pend = 0;
            if (pop && q.size() > 0) void'(q.pop_front());
            if (push) begin
                if (q.size() < DEPTH) q.push_back(pdata);
                else ovf_set = 1;
            end
            m_ovr = ovr_set || (m_ovr && !clear);
            m_ovf = ovf_set || (m_ovf && !clear);
            m_pa = aux; m_pg = gate; m_ps = smp;
        end
    end

    // Compare against the model at every falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R9 valid", 64'(fifo_valid), 64'(q.size() != 0));
            if (q.size() != 0) chk("R9 data", 64'(fifo_data), 64'(q[0]));
            chk("R8 overrun", 64'(overrun), 64'(m_ovr));
            chk("R10 overflow", 64'(overflow), 64'(m_ovf));
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    // Rising-polarity measurement lasting n ticks (n >= 1).
    task automatic measure(input int n);
        aux = 1; step();
        tick = 1;
        repeat (n - 1) step();
        gate = 1; step();
        aux = 0; gate = 0; tick = 0; step();
    endtask

    task automatic sample();
        smp = 1; step();
        smp = 0; step();
    endtask

    task automatic pop_one();
        pop = 1; step();
        pop = 0;
    endtask

    task automatic clear_flags();
        clear = 1; step();
        clear = 0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R11: reset state
        chk("R11 valid", 64'(fifo_valid), 64'd0);
        chk("R11 overrun", 64'(overrun), 64'd0);
        chk("R11 overflow", 64'(overflow), 64'd0);

        // R1: disarmed activity has no effect
        measure(3);
        sample();
        chk("R1 valid", 64'(fifo_valid), 64'd0);
        chk("R1 overrun", 64'(overrun), 64'd0);

        // R3 / R4 / R7: basic rising-edge measurement
        arm = 1; step();
        measure(5);
        sample();
        chk("R3 valid", 64'(fifo_valid), 64'd1);
        chk("R3 data", 64'(fifo_data), 64'd5);
        pop_one(); step();
        chk("R9 empty after pop", 64'(fifo_valid), 64'd0);

        // R5: repeated start edge during run is ignored
        aux = 1; step();
        tick = 1; step(); step();
        aux = 0; step();
        aux = 1; step();
        step();
        gate = 1; step();
        aux = 0; gate = 0; tick = 0; step();
        sample();
        chk("R5 data", 64'(fifo_data), 64'd6);
        pop_one();

        // R2: falling-edge polarity; rising transitions ignored
        aux_pol = 0; gate_pol = 0;
        aux = 1; tick = 1; step(); step();
        gate = 1; step();
        aux = 0; tick = 0; step();
        tick = 1; step(); step();
        gate = 0; step();
        tick = 0; step();
        sample();
        chk("R2 data", 64'(fifo_data), 64'd3);
        pop_one();
        aux_pol = 1; gate_pol = 1; step();

        // R4 / R8: idle stop edge ignored, empty period sets overrun
        gate = 1; step();
        gate = 0; step();
        sample();
        chk("R4 valid", 64'(fifo_valid), 64'd0);
        chk("R8 overrun set", 64'(overrun), 64'd1);
        clear_flags(); step();
        chk("R8 overrun cleared", 64'(overrun), 64'd0);
        smp = 1; clear = 1; step();
        smp = 0; clear = 0; step();
        chk("R8 set beats clear", 64'(overrun), 64'd1);
        clear_flags(); step();

        // R7: same-cycle completion wins; newest result per period
        measure(4);
        aux = 1; step();
        tick = 1; step();
        gate = 1; smp = 1; step();
        aux = 0; gate = 0; smp = 0; tick = 0; step();
        chk("R7 same-cycle data", 64'(fifo_data), 64'd2);
        pop_one();
        measure(2);
        measure(4);
        sample();
        chk("R7 newest data", 64'(fifo_data), 64'd4);
        chk("R7 no overrun", 64'(overrun), 64'd0);
        pop_one(); step();

        // R6: saturation
        aux = 1; step();
        tick = 1;
        repeat (300) step();
        gate = 1; step();
        aux = 0; gate = 0; tick = 0; step();
        sample();
        chk("R6 data", 64'(fifo_data), 64'(MAXV));
        pop_one(); step();

        // R1: disarm mid-run abandons the measurement
        aux = 1; step();
        tick = 1; repeat (3) step();
        arm = 0; step();
        gate = 1; step();
        aux = 0; gate = 0; tick = 0; step();
        arm = 1; step();
        sample();
        chk("R1 abandoned valid", 64'(fifo_valid), 64'd0);
        clear_flags(); step();

        // R10: full FIFO drops the newest write
        for (int k = 1; k <= DEPTH + 1; k++) begin
            measure(k);
            sample();
        end
        chk("R10 overflow set", 64'(overflow), 64'd1);
        chk("R10 head kept", 64'(fifo_data), 64'd1);
        clear_flags(); step();
        chk("R10 overflow cleared", 64'(overflow), 64'd0);
        for (int k = 1; k <= DEPTH; k++) begin
            chk("R10 stored order", 64'(fifo_data), 64'(k));
            pop_one(); step();
        end
        chk("R9 drained", 64'(fifo_valid), 64'd0);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end
endmodule